// File: doc/BRIEF.md
# DRAM Refresh Interval Scheduler

This block paces auto-refresh for a DDR2 memory controller. A down-counter measures the average refresh interval in controller clock cycles. Each time the interval runs out, one more refresh becomes owed. The block asks the command arbiter for a refresh while any refresh is owed. The arbiter answers with a one-cycle grant when it has put a REFRESH on the bus. Each accepted grant pays off one owed refresh. It also opens a busy window as long as the refresh cycle time, during which the arbiter must not issue an ACTIVE or another REFRESH.

When the device case runs hot, the refresh interval is half the normal one. The hot flag is sampled only when the interval counter reloads, so a change of temperature never shortens an interval that is already running. Owed refreshes may pile up to a postponement limit, and an urgent flag tells the arbiter that no more can be postponed. Interval and window lengths are given in picoseconds and turned into whole cycles, rounded up. With the defaults (2.5 ns clock, 7.8 µs interval, 127.5 ns window, limit 8) this gives 3120 cycles, 1560 cycles when hot, and 51 cycles.

Top module: `refresh_scheduler`

## Requirements
- R1: While `rst_n` is low at a clock edge, the owed count clears to 0, `busy_o`, `ref_req_o` and `ref_urgent_o` go low, and the interval counter reloads.
- R2: With `hot_i` low, the first expiry after reset release lands on the interval-length-th rising edge (for example, edge 40 when the interval is 40 cycles). Each later expiry follows one interval after the previous one. Every expiry raises `debt_o` by one.
- R3: An interval loaded while `hot_i` is high lasts half the normal interval, rounded up to whole cycles.
- R4: `hot_i` is sampled only at the edge where the interval counter reloads. A change in the middle of an interval neither shortens nor lengthens that interval.
- R5: `ref_req_o` is high exactly when `debt_o` is non-zero and `busy_o` is low.
- R6: A grant (`grant_i` high at an edge while `ref_req_o` is high) lowers `debt_o` by one. A grant while `debt_o` is zero, or while `busy_o` is high, is ignored: `debt_o` and `busy_o` do not change.
- R7: When an accepted grant and an expiry fall on the same edge, `debt_o` stays the same.
- R8: After an accepted grant, `busy_o` stays high for exactly the refresh cycle time, rounded up to whole cycles, and then falls.
- R9: `ref_urgent_o` is high when `debt_o` equals the postponement limit. An expiry at the limit is dropped, and `debt_o` saturates at the limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hot_i | input | 1 | Case temperature is in the high range |
| grant_i | input | 1 | Arbiter issued the requested REFRESH this cycle |
| ref_req_o | output | 1 | Refresh wanted: at least one refresh owed and no busy window open |
| ref_urgent_o | output | 1 | Owed count has reached the postponement limit |
| busy_o | output | 1 | Refresh cycle time running; no ACTIVE or REFRESH may be issued |
| debt_o | output | $clog2(POSTPONE_MAX+1) | Number of refreshes currently owed |

## Verification
The hardest case to reach from the ports is an accepted grant on the very edge where the interval expires. Next hardest is an expiry arriving while the owed count is already at the limit. Both need exact knowledge of where the interval counter stands. The stimulus therefore counts every edge from reset release. It toggles the hot flag at known points so that the interval lengths can be predicted. The bench builds up debt to the limit first. Then it places a grant on a computed edge so that it meets an expiry, and it attempts grants inside the busy window and with nothing owed.

// File: rtl/refsched_pkg.sv
// Package: refsched_pkg
// Shared helpers for the refresh scheduler. Converts picosecond timing
// values into whole clock cycles, always rounding up so that no timing
// minimum is ever shortened.
package refsched_pkg;

    // Rounds a duration in picoseconds up to a whole number of clock cycles.
    function automatic int ps_to_cycles(input int dur_ps, input int clk_ps);
        return (dur_ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/refsched_interval.sv
// Module: refsched_interval
// Down-counter for the average refresh interval. Emits a one-cycle expiry
// pulse, then reloads with the normal or the hot length. The length is
// picked from hot_i at the reload edge only.
// Assumes: NORM_CYC >= 2 and HOT_CYC >= 1.
module refsched_interval #(
    parameter int NORM_CYC = 3120,
    parameter int HOT_CYC  = 1560,
    localparam int CW      = $clog2(NORM_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_i,
    output logic expire_o
);

    localparam logic [CW-1:0] NORM_LD = CW'(NORM_CYC - 1);
    localparam logic [CW-1:0] HOT_LD  = CW'(HOT_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] reload_val;

    // Picks the reload value from the temperature flag.
    always_comb reload_val = hot_i ? HOT_LD : NORM_LD;

    // Counts down and reloads on reset or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_q == '0) begin
            cnt_q <= reload_val;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry is the cycle in which the counter sits at zero.
    always_comb expire_o = rst_n && (cnt_q == '0);

endmodule

// File: rtl/refsched_debt.sv
// Module: refsched_debt
// Saturating count of refreshes owed. Goes up by one on inc_i and down by
// one on dec_i; both together leave it unchanged. At LIMIT, an increment
// is dropped.
// Assumes: the caller asserts dec_i only while the count is non-zero.
module refsched_debt #(
    parameter int LIMIT = 8,
    localparam int DW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          dec_i,
    output logic [DW-1:0] debt_o
);

    localparam logic [DW-1:0] LIM_V = DW'(LIMIT);

    logic [DW-1:0] debt_q;

    // Updates the owed count: saturating increment, plain decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt_q <= '0;
        end else if (inc_i && !dec_i) begin
            if (debt_q != LIM_V) debt_q <= debt_q + 1'b1;
        end else if (dec_i && !inc_i) begin
            debt_q <= debt_q - 1'b1;
        end
    end

    // Drives the count out unchanged.
    always_comb debt_o = debt_q;

endmodule

// File: rtl/refsched_busy.sv
// Module: refsched_busy
// Refresh cycle time window. After start_i, busy_o is high for exactly
// WIN_CYC cycles. A zero-length window ties busy_o low.
// Assumes: start_i never arrives while the window is open.
module refsched_busy #(
    parameter int WIN_CYC = 51,
    localparam int BW     = $clog2(WIN_CYC + 1) < 1 ? 1 : $clog2(WIN_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    generate
        if (WIN_CYC == 0) begin : g_none
            // No window to time: busy never rises.
            always_comb busy_o = 1'b0;
        end else begin : g_win
            logic [BW-1:0] left_q;

            // Loads the window length on start and counts it down to zero.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    left_q <= '0;
                end else if (start_i) begin
                    left_q <= BW'(WIN_CYC);
                end else if (left_q != '0) begin
                    left_q <= left_q - 1'b1;
                end
            end

            // Busy while time is left in the window.
            always_comb busy_o = (left_q != '0);
        end
    endgenerate

endmodule

// File: rtl/refresh_scheduler.sv
// Module: refresh_scheduler
// Schedules periodic auto-refresh for a DDR2 controller. It counts the
// refresh interval, halving it when hot, and keeps a bounded count of
// owed refreshes. It requests a refresh while any is owed and blocks
// commands for the refresh cycle time after each granted refresh.
// Assumes: grant_i is a one-cycle pulse from the arbiter; durations are
// given in picoseconds.
module refresh_scheduler
    import refsched_pkg::*;
#(
    parameter int CLK_PS       = 2500,
    parameter int TREFI_PS     = 7_800_000,
    parameter int TRFC_PS      = 127_500,
    parameter int POSTPONE_MAX = 8,
    localparam int DEBT_W      = $clog2(POSTPONE_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hot_i,
    input  logic              grant_i,
    output logic              ref_req_o,
    output logic              ref_urgent_o,
    output logic              busy_o,
    output logic [DEBT_W-1:0] debt_o
);

    localparam int NORM_CYC = ps_to_cycles(TREFI_PS, CLK_PS);
    localparam int HOT_CYC  = ps_to_cycles(TREFI_PS / 2 + TREFI_PS % 2, CLK_PS);
    localparam int TRFC_CYC = ps_to_cycles(TRFC_PS, CLK_PS);
    localparam logic [DEBT_W-1:0] LIM_V = DEBT_W'(POSTPONE_MAX);

    logic expire;
    logic accept;
    logic busy;
    logic [DEBT_W-1:0] debt;

    refsched_interval #(
        .NORM_CYC(NORM_CYC),
        .HOT_CYC (HOT_CYC)
    ) u_interval (
        .clk     (clk),
        .rst_n   (rst_n),
        .hot_i   (hot_i),
        .expire_o(expire)
    );

    refsched_debt #(
        .LIMIT(POSTPONE_MAX)
    ) u_debt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (expire),
        .dec_i (accept),
        .debt_o(debt)
    );

    refsched_busy #(
        .WIN_CYC(TRFC_CYC)
    ) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(accept),
        .busy_o (busy)
    );

    // A grant counts only when a request is actually outstanding.
    always_comb accept = grant_i && ref_req_o;

    // Drives the arbiter-facing outputs.
    always_comb begin
        ref_req_o    = (debt != '0) && !busy;
        ref_urgent_o = (debt == LIM_V);
        busy_o       = busy;
        debt_o       = debt;
    end

endmodule

// File: rtl/refsched_checker.sv
// Module: refsched_checker
// Port-level properties of the refresh scheduler, attached by bind.
// Assumes: the same POSTPONE_MAX as the scheduler it is bound to.
module refsched_checker #(
    parameter int LIMIT = 8,
    parameter int DW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          grant_i,
    input logic          ref_req_o,
    input logic          ref_urgent_o,
    input logic          busy_o,
    input logic [DW-1:0] debt_o
);

    // R5: no request may be shown while the busy window is open
    p_no_req_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !ref_req_o);

    // R9: the owed count never exceeds the postponement limit
    p_debt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(debt_o) <= LIMIT);

    // R9: urgency outside a busy window implies a pending request
    p_urgent_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_urgent_o && !busy_o) |-> ref_req_o);

    // R6: the owed count moves by at most one per cycle
    p_debt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(debt_o) <= int'($past(debt_o)) + 1) &&
        (int'(debt_o) + 1 >= int'($past(debt_o))));

    // R8: an accepted grant opens the busy window on the next cycle
    p_grant_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && ref_req_o) |=> busy_o);

    // R8: the busy window only opens after a grant
    p_busy_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(grant_i));

endmodule

bind refresh_scheduler refsched_checker #(
    .LIMIT(POSTPONE_MAX),
    .DW   (DEBT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_i     (grant_i),
    .ref_req_o   (ref_req_o),
    .ref_urgent_o(ref_urgent_o),
    .busy_o      (busy_o),
    .debt_o      (debt_o)
);

// File: tb/tb_refresh_scheduler.sv
// Bench for refresh_scheduler with a short configuration:
// 1 ns cycle, 40-cycle interval (20 hot), 4.5 ns window (5 cycles), limit 4.
module tb_refresh_scheduler;

    localparam int LIM = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hot = 1'b0;
    logic       grant = 1'b0;
    logic       req, urgent, busy;
    logic [2:0] debt;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    refresh_scheduler #(
        .CLK_PS      (1000),
        .TREFI_PS    (40_000),
        .TRFC_PS     (4500),
        .POSTPONE_MAX(LIM)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hot_i       (hot),
        .grant_i     (grant),
        .ref_req_o   (req),
        .ref_urgent_o(urgent),
        .busy_o      (busy),
        .debt_o      (debt)
    );

    // Each row: hot value to drive, edges to advance, expected debt, expected urgent.
    localparam int VEC [9][4] = '{
        '{0, 39, 0, 0},   // R2 one edge before first expiry
        '{0,  1, 1, 0},   // R2 first expiry on edge 40
        '{1, 39, 1, 0},   // R4 hot raised mid-interval: no early expiry
        '{1,  1, 2, 0},   // R4 expiry still at full length
        '{1, 19, 2, 0},   // R3 hot interval running
        '{1,  1, 3, 0},   // R3 hot interval is 20 edges
        '{0, 19, 3, 0},   // R4 hot dropped mid-interval: still 20 edges
        '{0,  1, 4, 1},   // R9 limit reached, urgent
        '{0, 40, 4, 1}    // R9 expiry at limit dropped
    };

    // Records one comparison and reports a mismatch.
    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Advances n rising edges and settles 2 ns after the last one.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    // Pulses grant for one edge.
    task automatic pulse_grant();
        grant = 1'b1;
        step(1);
        grant = 1'b0;
    endtask

    initial begin
        step(3);
        check("R1 debt in reset", int'(debt), 0);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 req in reset", int'(req), 0);
        check("R1 urgent in reset", int'(urgent), 0);
        rst_n = 1'b1;

        for (int v = 0; v < 9; v++) begin
            hot = VEC[v][0][0];
            step(VEC[v][1]);
            check($sformatf("R2/R3/R4 vec%0d debt", v), int'(debt), VEC[v][2]);
            check($sformatf("R9 vec%0d urgent", v), int'(urgent), VEC[v][3]);
            check($sformatf("R5 vec%0d req", v), int'(req), VEC[v][2] != 0 ? 1 : 0);
        end
        // edge 160 now; next expiry on edge 200

        pulse_grant();                                   // edge 161
        check("R6 grant lowers debt", int'(debt), 3);
        check("R8 busy after grant", int'(busy), 1);
        check("R5 req low in busy", int'(req), 0);
        check("R9 urgent cleared", int'(urgent), 0);
        step(3);                                         // edge 164
        pulse_grant();                                   // edge 165, inside window
        check("R6 grant in busy ignored debt", int'(debt), 3);
        check("R8 busy still on 4th edge", int'(busy), 1);
        step(1);                                         // edge 166
        check("R8 busy off after 5 edges", int'(busy), 0);
        check("R5 req back", int'(req), 1);

        step(33);                                        // edge 199
        check("R7 debt before coincidence", int'(debt), 3);
        pulse_grant();                                   // edge 200: expiry + grant
        check("R7 debt unchanged", int'(debt), 3);
        check("R7 busy opened", int'(busy), 1);
        step(5);                                         // edge 205
        check("R8 window closed", int'(busy), 0);

        for (int k = 0; k < 3; k++) begin
            pulse_grant();
            check("R6 drain debt", int'(debt), 2 - k);
            step(5);
        end
        // edge 223
        check("R5 no req at zero debt", int'(req), 0);
        pulse_grant();                                   // edge 224
        check("R6 zero-debt grant ignored debt", int'(debt), 0);
        check("R6 zero-debt grant no busy", int'(busy), 0);

        step(16);                                        // edge 240 expiry
        check("R2 periodic expiry", int'(debt), 1);
        rst_n = 1'b0;
        step(1);
        check("R1 reset clears debt", int'(debt), 0);
        check("R1 reset clears req", int'(req), 0);
        rst_n = 1'b1;
        step(39);
        check("R1 interval reloaded", int'(debt), 0);
        step(1);
        check("R1 R2 expiry after reload", int'(debt), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Ends a hung run as a failure.
    initial begin
        #(8 * 200_000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule